// File: doc/BRIEF.md
# Reset Control and Interrupt Source Register

This block is one 8-bit register on a simple memory-mapped bus. It brings the chip's reset sources together into one system reset and keeps a record of which of three event sources raised an interrupt. The sources are an alarm, a supply-voltage supervisor and a secondary watchdog. It also holds a few static control bits: an enable for the I2C output path, a clamp for the oscillator input, the clock source select, and a switch that masks the internal CPU reset request.

The external reset pin is active low and open drain. The block drives the pin low on request through `pad_drive_o`. Any other device on the board may also pull the pin low. The block samples the pin through a synchronizer, and every pull-down on the pin therefore becomes one system-wide reset. Software reads the register to find the cause of an interrupt. It clears a flag by writing 1 to that flag's bit. The clear is refused while the source is still asserted.

Top module: `rstctl_reg`

## Requirements
- R1: After reset the register reads 0x08 (flags 0, bit 4 = 0, bit 3 = 1, bits 2 and 1 = 0, bit 0 reads 0). `pad_drive_o` and `irq_o` are 0.
- R2: A 0-to-1 change on `src_i[0]`, `src_i[1]` or `src_i[2]` sets the flag at bit 5, 6 or 7 respectively. The flag reads 1 from the clock edge that samples the rising level.
- R3: A write with 1 in a flag bit clears that flag when its source is low. A write with 0 in a flag bit leaves the flag unchanged.
- R4: While a source is high, its flag stays at 1. This holds even when a clear write for that flag falls in the same cycle as the rising edge or in any later cycle.
- R5: `irq_o` is high for exactly the one cycle after the edge at which any flag goes from 0 to 1. A refused clear raises no pulse.
- R6: Bits 4..1 are read/write. Bit 4 drives `bus_out_en_o`, bit 3 drives `osc_clamp_o`, bit 2 drives `clk_pll_sel_o` (1 = PLL) and bit 1 is the internal-reset disable.
- R7: Bit 0 is write-only. Writing 1 sets `pad_drive_o` and writing 0 clears it. Bit 0 always reads 0.
- R8: A write takes effect only when both `sel_i` and `wr_i` are high. `rdata_o` is 0 while `sel_i` is low.
- R9: `sys_rst_o` is high from the second clock edge after `pad_rst_ni` is first sampled low. It stays high until the second edge after the pin is sampled high again.
- R10: `core_rst_req_i` asserts `sys_rst_o` in the same cycle while bit 1 is 0. The request has no effect while bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the register |
| sel_i | input | 1 | Register address decode hit |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not selected |
| src_i | input | 3 | Event levels: [0] secondary watchdog, [1] supply supervisor, [2] alarm |
| pad_rst_ni | input | 1 | Level on the open-drain reset pin |
| pad_drive_o | output | 1 | Request to pull the reset pin low |
| core_rst_req_i | input | 1 | Internal CPU reset request |
| sys_rst_o | output | 1 | Combined system reset, active high |
| bus_out_en_o | output | 1 | I2C output enable |
| osc_clamp_o | output | 1 | Clamp the oscillator input to zero |
| clk_pll_sel_o | output | 1 | Clock source select, 1 = PLL |
| irq_o | output | 1 | One-cycle pulse on a newly set flag |

## Verification
The main collision is a software clear and a hardware set on the same flag in the same cycle. The bench raises a source at the negative edge and issues a write of 1 to that flag's bit in the same bus cycle. The flag must survive and `irq_o` must pulse. The bench also holds a source high across later clear writes, and the flag must stay set with no new pulse. A second overlap joins the register's own pin drive to an external pull-down on the shared reset pin. The cycle-level reference model judges `sys_rst_o` after each edge.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_SRC  = 3;
    localparam int CTRL_W   = 4;
    localparam int PAD_BIT  = 0;
    localparam int CTRL_LSB = PAD_BIT + 1;
    localparam int FLAG_LSB = CTRL_LSB + CTRL_W;

    // index of each control bit inside the ctrl field
    localparam int C_RSTDIS = 0;
    localparam int C_CLKSEL = 1;
    localparam int C_CLAMP  = 2;
    localparam int C_BUSOUT = 3;

    localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0100;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              pad_drv;
        logic              irq;
    } regs_t;

    typedef struct packed {
        logic src_prev;
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/rstctl_flag.sv
module rstctl_flag
    import rstctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic clr_i,
    output logic flag_o,
    output logic set_o
);

    flag_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.src_prev = src_i;
        // set on rising edge; a clear only lands while the source is low
        s_d.flag     = (src_i & ~s_q.src_prev) | (s_q.flag & ~(clr_i & ~src_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flag_o = s_q.flag;
    assign set_o  = s_d.flag & ~s_q.flag;

endmodule

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/rstctl_reg.sv
module rstctl_reg
    import rstctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               pad_rst_ni,
    output logic               pad_drive_o,
    input  logic               core_rst_req_i,
    output logic               sys_rst_o,
    output logic               bus_out_en_o,
    output logic               osc_clamp_o,
    output logic               clk_pll_sel_o,
    output logic               irq_o
);

    logic               wr_en;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] flag_set;
    logic               pin_sync;
    regs_t              r_d, r_q;

    assign wr_en   = sel_i & wr_i;
    assign clr_vec = wr_en ? wdata_i[FLAG_LSB +: NUM_SRC] : '0;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            rstctl_flag u_flag (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .src_i  (src_i[g]),
                .clr_i  (clr_vec[g]),
                .flag_o (flags_q[g]),
                .set_o  (flag_set[g])
            );
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.ctrl    = wdata_i[CTRL_LSB +: CTRL_W];
            r_d.pad_drv = wdata_i[PAD_BIT];
        end
        r_d.irq = |flag_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{ctrl: CTRL_RST, pad_drv: 1'b0, irq: 1'b0};
        else         r_q <= r_d;
    end

    rstctl_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_pin_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_rst_ni),
        .q_o    (pin_sync)
    );

    assign sys_rst_o     = ~pin_sync | (core_rst_req_i & ~r_q.ctrl[C_RSTDIS]);
    assign rdata_o       = sel_i ? {flags_q, r_q.ctrl, 1'b0} : '0;
    assign pad_drive_o   = r_q.pad_drv;
    assign bus_out_en_o  = r_q.ctrl[C_BUSOUT];
    assign osc_clamp_o   = r_q.ctrl[C_CLAMP];
    assign clk_pll_sel_o = r_q.ctrl[C_CLKSEL];
    assign irq_o         = r_q.irq;

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
    import rstctl_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] flags_q,
    input logic               irq_o,
    input logic               sel_i,
    input logic               wr_i,
    input logic [REG_W-1:0]   wdata_i,
    input logic               pad_drive_o,
    input logic               pad_rst_ni,
    input logic               sys_rst_o,
    input logic               clk_pll_sel_o
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
            // R2
            flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(src_i[g]) |=> flags_q[g]);
            // R4
            flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (src_i[g] && flags_q[g]) |=> flags_q[g]);
        end
    endgenerate

    // R5
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((flags_q & ~$past(flags_q)) != '0));

    // R7
    pad_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i) |=> (pad_drive_o == $past(wdata_i[PAD_BIT])));

    // R6
    clksel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i) |=> (clk_pll_sel_o == $past(wdata_i[CTRL_LSB + C_CLKSEL])));

    // R9
    pin_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pad_rst_ni && $past(!pad_rst_ni)) |=> sys_rst_o);

endmodule

bind rstctl_reg rstctl_chk chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .src_i         (src_i),
    .flags_q       (flags_q),
    .irq_o         (irq_o),
    .sel_i         (sel_i),
    .wr_i          (wr_i),
    .wdata_i       (wdata_i),
    .pad_drive_o   (pad_drive_o),
    .pad_rst_ni    (pad_rst_ni),
    .sys_rst_o     (sys_rst_o),
    .clk_pll_sel_o (clk_pll_sel_o)
);

// File: tb/rstctl_reg_tb_top.sv
module rstctl_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, sel, wr, ext_low, core_req;
    logic [7:0] wdata;
    logic [2:0] src;
    logic [7:0] rdata;
    logic       pad_drive, sys_rst, bus_en, clamp, pll_sel, irq;
    wire        pin_n = ~(ext_low | pad_drive);

    always #4 clk = ~clk;

    rstctl_reg dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .sel_i          (sel),
        .wr_i           (wr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .src_i          (src),
        .pad_rst_ni     (pin_n),
        .pad_drive_o    (pad_drive),
        .core_rst_req_i (core_req),
        .sys_rst_o      (sys_rst),
        .bus_out_en_o   (bus_en),
        .osc_clamp_o    (clamp),
        .clk_pll_sel_o  (pll_sel),
        .irq_o          (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";

    // behavioural reference
    bit [2:0] m_flag, m_prev, m_clr, m_next;
    bit [3:0] m_ctrl;
    bit       m_pad, m_irq, m_pin;
    bit       pin_hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_prev = 0; m_ctrl = 4'b0100; m_pad = 0; m_irq = 0;
            pin_hist = {1'b0, 1'b0};
        end else begin
            m_pin  = ~(ext_low | m_pad);
            m_clr  = (sel && wr) ? wdata[7:5] : 3'b000;
            m_next = (src & ~m_prev) | (m_flag & ~(m_clr & ~src));
            m_irq  = (m_next & ~m_flag) != 0;
            m_flag = m_next;
            m_prev = src;
            if (sel && wr) begin
                m_ctrl = wdata[4:1];
                m_pad  = wdata[0];
            end
            pin_hist.push_back(m_pin);
            void'(pin_hist.pop_front());
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        chk("rdata", rdata, sel ? {m_flag, m_ctrl, 1'b0} : 8'h00);
        chk("pad_drive", {7'b0, pad_drive}, {7'b0, m_pad});
        chk("irq", {7'b0, irq}, {7'b0, m_irq});
        chk("bus_en", {7'b0, bus_en}, {7'b0, m_ctrl[3]});
        chk("clamp", {7'b0, clamp}, {7'b0, m_ctrl[2]});
        chk("pll_sel", {7'b0, pll_sel}, {7'b0, m_ctrl[1]});
        chk("sys_rst", {7'b0, sys_rst},
            {7'b0, ~pin_hist[0] | (core_req & ~m_ctrl[0])});
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(logic [7:0] d);
        @(negedge clk);
        sel = 1; wr = 1; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 0; sel = 0; wr = 0; wdata = 0; src = 0; ext_low = 0; core_req = 0;
        cyc(3);
        rst_n = 1;
        phase = "R1"; sel = 1; cyc(3);

        phase = "R6";
        wreg(8'h1E); cyc(2); wreg(8'h00); cyc(2); wreg(8'h14); cyc(1); wreg(8'h08);

        phase = "R7";
        wreg(8'h09); cyc(5); wreg(8'h08); cyc(4);

        phase = "R8";
        sel = 0; wr = 1; wdata = 8'hFF; cyc(2);
        wr = 0; sel = 1; cyc(2);

        phase = "R2";
        for (int i = 0; i < 3; i++) begin
            src = 3'(1 << i); cyc(2); src = 0; cyc(1);
        end

        phase = "R3";
        wreg(8'h28); cyc(1); wreg(8'h08); cyc(1); wreg(8'hE8); cyc(2);

        phase = "R5";
        src = 3'b110; cyc(1); src = 3'b111; cyc(3); src = 0; cyc(1);
        src = 3'b101; cyc(1); src = 0; cyc(2);

        phase = "R4";
        src = 3'b111; cyc(1);
        wreg(8'hE8); cyc(2);
        src = 0; wreg(8'hE8); cyc(1);
        @(negedge clk);
        src = 3'b011; sel = 1; wr = 1; wdata = 8'hE8;
        @(negedge clk);
        wr = 0; cyc(2);
        src = 0; wreg(8'hE8); cyc(2);

        phase = "R9";
        ext_low = 1; cyc(1); ext_low = 0; cyc(3);
        ext_low = 1; cyc(5); ext_low = 0; cyc(4);

        phase = "R10";
        core_req = 1; cyc(2);
        wreg(8'h0A); cyc(2);
        core_req = 0; cyc(1); core_req = 1; cyc(1);
        wreg(8'h08); cyc(2);
        core_req = 0; cyc(2);

        finish_run();
    end

endmodule